// File: doc/BRIEF.md
# Interrupt Destination Arbiter

This block decides which processor agents receive an inter-processor interrupt. A request carries an 8-bit destination, a physical/logical mode bit, a 2-bit shorthand, a 3-bit delivery mode and the index of the sending agent. Each of the N agents supplies:

- its physical ID,
- its 32-bit logical destination register, whose top byte is the logical ID,
- a 4-bit destination-format code,
- a present flag,
- an enabled flag.

One cycle after a request, the block drives a target mask for one clock. The valid strobe is high in that same cycle.

For ordinary delivery modes, the mask names every present agent that matches the destination. For lowest-priority delivery, at most one agent is named. The block first builds the set of matching agents that are present and enabled. It then scans that set in rotating order, starting at the agent after the one chosen last. A registered pointer remembers the last choice. The block does not deliver vectors and does not evaluate priorities.

Top module: `ipi_dest_arbiter`

## Requirements
- R1: After reset, tgt_valid_o is 0 and tgt_mask_o is all zeros. The rotation pointer rests on agent N-1, so the first lowest-priority scan begins at agent 0.
- R2: Shorthand 0 with physical mode (logical_i=0): an agent matches when dest_i equals its physical ID, or when dest_i is 8'hFF.
- R3: Shorthand 0, logical mode, format code 4'hF (flat): an agent matches when the AND of its logical ID and dest_i is nonzero. The logical ID is bits 31:24 of its logical destination register, and bits 23:0 are ignored.
- R4: Shorthand 0, logical mode, format code 4'h0 (cluster): an agent matches when the upper nibbles of its logical ID and dest_i are equal and the AND of the lower nibbles is nonzero.
- R5: In logical mode, an agent whose format code is neither 4'hF nor 4'h0 never matches. Physical-mode matching ignores the format code.
- R6: Shorthand 1 (self) matches only the agent indexed by src_i, whatever dest_i and logical_i hold.
- R7: Shorthand 2 matches every agent. Shorthand 3 matches every agent except src_i.
- R8: An agent whose present flag is 0 never appears in the target mask.
- R9: For any delivery mode other than 3'b001, the mask is the set of present matching agents, regardless of the enabled flags.
- R10: For delivery mode 3'b001 (lowest priority), the mask holds exactly one agent when any exists, and otherwise none. The agent is the first one that matches, is present and is enabled, scanning from the pointer plus 1 upward and wrapping past N-1 back to the pointer itself.
- R11: A lowest-priority request that picks an agent moves the pointer to that agent. A request that finds no candidate gives an all-zero mask and leaves the pointer unchanged.
- R12: tgt_valid_o is high in exactly the cycle after the cycle in which req_valid_i is sampled high. The result is registered once, and tgt_mask_o is zero whenever tgt_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| dest_i | input | ID_W | Destination field |
| logical_i | input | 1 | 1 = logical destination mode |
| shorthand_i | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| dlv_mode_i | input | 3 | Delivery mode, 3'b001 = lowest priority |
| src_i | input | IDX_W | Index of the sending agent |
| phys_id_i | input | N_AGENTS*ID_W | Physical IDs, agent i at [i*ID_W +: ID_W] |
| ldr_i | input | N_AGENTS*LDR_W | Logical destination registers, per agent |
| fmt_i | input | N_AGENTS*FMT_W | Destination-format codes, per agent |
| present_i | input | N_AGENTS | Agent exists |
| enabled_i | input | N_AGENTS | Agent may take lowest-priority interrupts |
| tgt_valid_o | output | 1 | Result strobe |
| tgt_mask_o | output | N_AGENTS | Selected agents |

## Verification
The destination matcher is swept over all 256 destination values in three configurations:

- **Physical IDs with a duplicate.** This separates exact-ID hits from the 8'hFF broadcast and shows that more than one agent can be hit.
- **One-hot flat logical IDs with junk in the low register bits.** This shows that only the top byte is used.
- **Cluster IDs mixed with unrecognised format codes.** This separates the nibble-equality test from the member AND and from format rejection.

The shorthands are tried for every sending index.

Lowest-priority sequences are then run with shifting present and enabled patterns. Among them are empty candidate sets, which show whether the pointer is held, and runs with all agents eligible, which show whether the rotation wraps.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;
  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [2:0] DLV_LOWEST  = 3'b001;
endpackage

// File: rtl/ipi_agent_match.sv
module ipi_agent_match
  import ipi_dest_pkg::*;
#(
  parameter int ID_W      = 8,
  parameter int LDR_W     = 32,
  parameter int FMT_W     = 4,
  parameter int IDX_W     = 3,
  parameter int AGENT_IDX = 0
) (
  input  logic [ID_W-1:0]  dest_i,
  input  logic             logical_i,
  input  logic [1:0]       shorthand_i,
  input  logic [IDX_W-1:0] src_i,
  input  logic [ID_W-1:0]  phys_id_i,
  input  logic [LDR_W-1:0] ldr_i,
  input  logic [FMT_W-1:0] fmt_i,
  output logic             hit_o
);
  localparam int NIB = ID_W / 2;

  logic [ID_W-1:0] lid;
  logic            is_self;
  logic            phys_hit;
  logic            flat_hit;
  logic            clus_hit;
  logic            log_hit;

  assign lid     = ldr_i[LDR_W-1 -: ID_W];
  assign is_self = (src_i == IDX_W'(AGENT_IDX));

  assign phys_hit = (dest_i == phys_id_i) || (dest_i == {ID_W{1'b1}});
  assign flat_hit = |(lid & dest_i);
  assign clus_hit = (lid[ID_W-1 -: NIB] == dest_i[ID_W-1 -: NIB]) &&
                    (|(lid[NIB-1:0] & dest_i[NIB-1:0]));

  always_comb begin
    if (fmt_i == FMT_W'(FMT_FLAT))         log_hit = flat_hit;
    else if (fmt_i == FMT_W'(FMT_CLUSTER)) log_hit = clus_hit;
    else                                   log_hit = 1'b0;
  end

  always_comb begin
    unique case (shorthand_i)
      SH_NONE:   hit_o = logical_i ? log_hit : phys_hit;
      SH_SELF:   hit_o = is_self;
      SH_ALL:    hit_o = 1'b1;
      SH_OTHERS: hit_o = !is_self;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N_AGENTS = 8,
  parameter int IDX_W    = 3
) (
  input  logic [N_AGENTS-1:0] cand_i,
  input  logic [IDX_W-1:0]    last_i,
  output logic [N_AGENTS-1:0] pick_o,
  output logic [IDX_W-1:0]    pick_idx_o,
  output logic                found_o
);
  // scan last+1 .. last, wrapping; first candidate wins
  always_comb begin
    pick_o     = '0;
    pick_idx_o = last_i;
    found_o    = 1'b0;
    for (int k = 1; k <= N_AGENTS; k++) begin
      int p;
      p = (int'(last_i) + k) % N_AGENTS;
      if (!found_o && cand_i[p]) begin
        found_o    = 1'b1;
        pick_o[p]  = 1'b1;
        pick_idx_o = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/ipi_dest_arbiter.sv
module ipi_dest_arbiter
  import ipi_dest_pkg::*;
#(
  parameter int  N_AGENTS = 8,
  parameter int  ID_W     = 8,
  parameter int  LDR_W    = 32,
  parameter int  FMT_W    = 4,
  localparam int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [ID_W-1:0]           dest_i,
  input  logic                      logical_i,
  input  logic [1:0]                shorthand_i,
  input  logic [2:0]                dlv_mode_i,
  input  logic [IDX_W-1:0]          src_i,
  input  logic [N_AGENTS*ID_W-1:0]  phys_id_i,
  input  logic [N_AGENTS*LDR_W-1:0] ldr_i,
  input  logic [N_AGENTS*FMT_W-1:0] fmt_i,
  input  logic [N_AGENTS-1:0]       present_i,
  input  logic [N_AGENTS-1:0]       enabled_i,
  output logic                      tgt_valid_o,
  output logic [N_AGENTS-1:0]       tgt_mask_o
);
  logic [N_AGENTS-1:0] hit;
  logic [N_AGENTS-1:0] multi_mask;
  logic [N_AGENTS-1:0] lp_cand;
  logic [N_AGENTS-1:0] lp_pick;
  logic [IDX_W-1:0]    lp_idx;
  logic                lp_found;
  logic                is_lowest;
  logic [N_AGENTS-1:0] next_mask;

  logic                valid_q;
  logic [N_AGENTS-1:0] mask_q;
  logic [IDX_W-1:0]    last_q;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_match
    ipi_agent_match #(
      .ID_W     (ID_W),
      .LDR_W    (LDR_W),
      .FMT_W    (FMT_W),
      .IDX_W    (IDX_W),
      .AGENT_IDX(g)
    ) u_match (
      .dest_i     (dest_i),
      .logical_i  (logical_i),
      .shorthand_i(shorthand_i),
      .src_i      (src_i),
      .phys_id_i  (phys_id_i[g*ID_W +: ID_W]),
      .ldr_i      (ldr_i[g*LDR_W +: LDR_W]),
      .fmt_i      (fmt_i[g*FMT_W +: FMT_W]),
      .hit_o      (hit[g])
    );
  end

  assign multi_mask = hit & present_i;
  assign lp_cand    = multi_mask & enabled_i;
  assign is_lowest  = (dlv_mode_i == DLV_LOWEST);

  ipi_rr_pick #(
    .N_AGENTS(N_AGENTS),
    .IDX_W   (IDX_W)
  ) u_pick (
    .cand_i    (lp_cand),
    .last_i    (last_q),
    .pick_o    (lp_pick),
    .pick_idx_o(lp_idx),
    .found_o   (lp_found)
  );

  assign next_mask = is_lowest ? lp_pick : multi_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
      last_q  <= IDX_W'(N_AGENTS - 1);
    end else begin
      valid_q <= req_valid_i;
      mask_q  <= req_valid_i ? next_mask : '0;
      if (req_valid_i && is_lowest && lp_found) last_q <= lp_idx;
    end
  end

  assign tgt_valid_o = valid_q;
  assign tgt_mask_o  = mask_q;
endmodule

// File: rtl/ipi_dest_arbiter_chk.sv
module ipi_dest_arbiter_chk
  import ipi_dest_pkg::*;
#(
  parameter int N_AGENTS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic [1:0]          shorthand_i,
  input logic [2:0]          dlv_mode_i,
  input logic [N_AGENTS-1:0] present_i,
  input logic [N_AGENTS-1:0] enabled_i,
  input logic                tgt_valid_o,
  input logic [N_AGENTS-1:0] tgt_mask_o
);
  assert_valid_follows_req_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> tgt_valid_o);

  assert_valid_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !tgt_valid_o);

  assert_mask_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_valid_o |-> (tgt_mask_o == '0));

  assert_absent_untargeted_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ((tgt_mask_o & ~$past(present_i)) == '0));

  assert_lowest_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dlv_mode_i == DLV_LOWEST) |=> $onehot0(tgt_mask_o));

  assert_lowest_enabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dlv_mode_i == DLV_LOWEST) |=> ((tgt_mask_o & ~$past(enabled_i)) == '0));

  assert_self_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && shorthand_i == SH_SELF) |=> ($countones(tgt_mask_o) <= 1));
endmodule

bind ipi_dest_arbiter ipi_dest_arbiter_chk #(.N_AGENTS(N_AGENTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .shorthand_i(shorthand_i),
  .dlv_mode_i (dlv_mode_i),
  .present_i  (present_i),
  .enabled_i  (enabled_i),
  .tgt_valid_o(tgt_valid_o),
  .tgt_mask_o (tgt_mask_o)
);

// File: tb/ipi_dest_arbiter_tb.sv
`timescale 1ns/1ps
module ipi_dest_arbiter_tb_top;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [7:0]    dest_i = '0;
  logic          logical_i = 1'b0;
  logic [1:0]    shorthand_i = '0;
  logic [2:0]    dlv_mode_i = '0;
  logic [IW-1:0] src_i = '0;
  logic [N*8-1:0]  phys_id_i;
  logic [N*32-1:0] ldr_i;
  logic [N*4-1:0]  fmt_i;
  logic [N-1:0]  present_i = '1;
  logic [N-1:0]  enabled_i = '1;
  logic          tgt_valid_o;
  logic [N-1:0]  tgt_mask_o;

  logic [7:0]  phys [N];
  logic [31:0] ldr  [N];
  logic [3:0]  fmt  [N];

  for (genvar g = 0; g < N; g++) begin : g_pack
    assign phys_id_i[g*8 +: 8] = phys[g];
    assign ldr_i[g*32 +: 32]   = ldr[g];
    assign fmt_i[g*4 +: 4]     = fmt[g];
  end

  always #10 clk_i = ~clk_i;

  ipi_dest_arbiter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .dest_i(dest_i), .logical_i(logical_i), .shorthand_i(shorthand_i),
    .dlv_mode_i(dlv_mode_i), .src_i(src_i), .phys_id_i(phys_id_i),
    .ldr_i(ldr_i), .fmt_i(fmt_i), .present_i(present_i),
    .enabled_i(enabled_i), .tgt_valid_o(tgt_valid_o), .tgt_mask_o(tgt_mask_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int rr     = N - 1;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit hit(int i);
    logic [7:0] lid;
    lid = ldr[i][31:24];
    case (shorthand_i)
      2'd0: begin
        if (!logical_i) return (dest_i == phys[i]) || (dest_i == 8'hFF);
        if (fmt[i] == 4'hF) return (lid & dest_i) != 0;
        if (fmt[i] == 4'h0) return (lid[7:4] == dest_i[7:4]) && ((lid[3:0] & dest_i[3:0]) != 0);
        return 0;
      end
      2'd1:    return i == int'(src_i);
      2'd2:    return 1;
      default: return i != int'(src_i);
    endcase
  endfunction

  // runs one request from a negedge, checks result at the following negedge
  task automatic run_req(input string tag);
    logic [N-1:0] exp, cand;
    exp = '0;
    for (int i = 0; i < N; i++) cand[i] = hit(i) && present_i[i];
    if (dlv_mode_i == 3'b001) begin
      cand = cand & enabled_i;
      for (int k = 1; k <= N; k++) begin
        int p;
        p = (rr + k) % N;
        if (exp == '0 && cand[p]) begin
          exp[p] = 1'b1;
          rr = p;
        end
      end
    end else begin
      exp = cand;
    end
    req_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(tgt_valid_o === 1'b1, {tag, " R12 valid"}, 32'(tgt_valid_o), 32'd1);
    chk(tgt_mask_o === exp, tag, 32'(tgt_mask_o), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      phys[i] = 8'(i * 3 + 1);
      ldr[i]  = 32'h00ABCDEF;
      fmt[i]  = 4'hF;
    end
    phys[5] = phys[2];
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(tgt_valid_o === 1'b0, "R1 valid", 32'(tgt_valid_o), 0);
    chk(tgt_mask_o === '0, "R1 mask", 32'(tgt_mask_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(tgt_valid_o === 1'b0 && tgt_mask_o === '0, "R1 idle", 32'(tgt_mask_o), 0);

    // R1/R10: first lowest-priority pick is agent 0
    shorthand_i = 2'd2; dlv_mode_i = 3'b001;
    run_req("R1 R10 first pick");
    chk(tgt_mask_o === 8'h01, "R1 first agent", 32'(tgt_mask_o), 1);
    @(negedge clk_i);
    chk(tgt_valid_o === 1'b0 && tgt_mask_o === '0, "R12 pulse", 32'(tgt_mask_o), 0);

    // R2/R5: physical sweep, agent 6 has bad format but still matches physically
    dlv_mode_i = 3'b000; shorthand_i = 2'd0; logical_i = 1'b0;
    fmt[6] = 4'h5;
    for (int d = 0; d < 256; d++) begin
      dest_i = 8'(d);
      run_req("R2 R5 physical");
    end

    // R3: flat logical, one-hot IDs, low bits junk
    logical_i = 1'b1;
    for (int i = 0; i < N; i++) begin
      ldr[i] = {8'(1 << i), 24'h5A5A5A};
      fmt[i] = 4'hF;
    end
    for (int d = 0; d < 256; d++) begin
      dest_i = 8'(d);
      run_req("R3 flat");
    end

    // R4/R5: cluster with two agents holding unrecognised formats
    for (int i = 0; i < N; i++) begin
      ldr[i] = {4'(i >> 1), 4'(1 << (i % 4)), 24'hFFFFFF};
      fmt[i] = 4'h0;
    end
    fmt[6] = 4'h7; fmt[7] = 4'hE;
    for (int d = 0; d < 256; d++) begin
      dest_i = 8'(d);
      run_req("R4 R5 cluster");
    end
    dest_i = 8'h31;
    run_req("R5 bad format");
    chk(tgt_mask_o[6] === 1'b0, "R5 no match", 32'(tgt_mask_o), 0);

    // R6/R7: shorthands from every source
    dest_i = 8'h00;
    for (int s = 0; s < N; s++) begin
      src_i = IW'(s);
      for (int sh = 1; sh < 4; sh++) begin
        shorthand_i = 2'(sh);
        run_req(sh == 1 ? "R6 self" : "R7 all");
      end
    end

    // R8/R9: absent agents, enabled ignored for fixed delivery
    present_i = 8'b1011_0101; enabled_i = 8'b0000_0011; shorthand_i = 2'd2;
    run_req("R8 R9 fixed");
    chk(tgt_mask_o === 8'b1011_0101, "R9 enabled ignored", 32'(tgt_mask_o), 32'hB5);

    // R10/R11: lowest-priority rotation with varied sets
    dlv_mode_i = 3'b001;
    present_i = '1; enabled_i = '1;
    for (int n = 0; n < 12; n++) run_req("R10 wrap");
    for (int n = 0; n < 96; n++) begin
      present_i   = 8'((n * 53) ^ 8'hC3);
      enabled_i   = (n % 7 == 3) ? 8'h00 : 8'((n * 37) | (n >> 2));
      shorthand_i = 2'(n % 4);
      src_i       = IW'(n);
      dest_i      = 8'((n * 29) ^ 8'h17);
      logical_i   = n[0];
      run_req("R10 R11 lowest");
    end
    enabled_i = 8'h00;
    run_req("R11 none");
    chk(tgt_mask_o === '0, "R11 empty", 32'(tgt_mask_o), 0);
    enabled_i = 8'hFF; present_i = 8'hFF; shorthand_i = 2'd2;
    run_req("R11 pointer held");

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule